// File: doc/BRIEF.md
# Vector Dot Product over a Shared Dual-Port Memory

This block computes the dot product of two vectors of unsigned integers. The two vectors are called a and b. Their elements arrive one at a time on two separate valid/ready input channels, and the channels may interleave in any way. Every accepted element is written into one shared dual-port synchronous memory. The memory is split by address: the a elements fill the lower half and the b elements fill the upper half.

Once both vectors are complete, the control logic reads matching pairs. Port 1 reads the lower half and port 2 reads the upper half, both in the same cycle. The read data only appears after the next rising edge, so each pair is multiplied and added one cycle after its read is issued. One extra drain cycle absorbs the last read. The sum is then offered on a valid/ready output channel. When the result is taken, the block returns to idle, clears its accumulator and opens a new load phase.

The memory is a behavioural model. Each port has its own address, data-in and data-out, and its own active-low write-enable, output-enable and chip-select. A port writes when its write-enable is low and reads when it is high. The output-enable and chip-select pins are tied low. Both reads and writes take effect on the rising clock edge.

Top module: `dotp_top`

## Requirements
- R1: While rstN is low, aReady, bReady and resValid are low and resData is zero. A reset in the middle of loading discards the elements already taken, so the next result counts only elements accepted after reset.
- R2: During loading, aReady stays high until exactly VEC_LEN (16) a elements have been accepted, then stays low until the next run. bReady behaves the same way for b, independently of a. Beats offered while ready is low are not stored.
- R3: The i-th accepted a element is paired with the i-th accepted b element, whatever the interleaving of the two channels. a is stored at addresses 0 to 15 of the shared memory and b at addresses 16 to 31.
- R4: resData equals the unsigned sum of a_i*b_i over all 16 pairs, held in ACC_W = 36 bits without wrap. With every element at 0xFFFF the result is 68717379600.
- R5: resValid rises exactly 17 rising edges after the edge that accepted the last outstanding element of the two vectors. This covers 16 read cycles, one drain cycle and the transition to the result.
- R6: While resReady is low, resValid stays high and resData stays unchanged. The edge with resReady high completes the transfer: resValid is low in the next cycle, and the next run starts from a zero accumulator.
- R7: From the edge that accepted the last element until the result is taken, aReady and bReady are both low, whatever is driven on aValid and bValid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| aData | input | DATA_W (16) | Element of vector a |
| aValid | input | 1 | aData holds an element |
| aReady | output | 1 | Block takes an a element this cycle |
| bData | input | DATA_W (16) | Element of vector b |
| bValid | input | 1 | bData holds an element |
| bReady | output | 1 | Block takes a b element this cycle |
| resData | output | ACC_W (36) | Dot product result |
| resValid | output | 1 | resData holds a finished result |
| resReady | input | 1 | Consumer takes the result |

## Verification
The embedded properties check the following on every cycle:
- the load phase ends only with both element counts full;
- the drain cycle always carries an accumulate;
- the result channel holds while stalled;
- the input channels stay quiet after loading;
- the accumulator never shrinks during an accumulate and never moves when it is idle.

Other behaviours can only be shown by the bench scenarios, because they depend on values carried through the memory:
- the pairing of elements by arrival order under lockstep, a-first, b-first and pseudo-random stalled interleavings;
- the exact sum at the all-ones extreme;
- the 17-edge latency;
- the loss of partial vectors after a reset in mid-load.

// File: rtl/dotp_pkg.sv
package dotp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_COMPUTE,
    ST_DRAIN,
    ST_DONE
  } dotState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrAcc;   // zero the accumulator
    logic macEn;    // add product of the two read words
    logic we1N;     // port 1 write enable, active low
    logic we2N;     // port 2 write enable, active low
  } dpStrobe_t;

endpackage

// File: rtl/dotp_sram.sv
module dotp_sram #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              p1WeN,
  input  logic              p1OeN,
  input  logic              p1CsN,
  input  logic [ADDR_W-1:0] p1Addr,
  input  logic [DATA_W-1:0] p1Din,
  output logic [DATA_W-1:0] p1Dout,
  input  logic              p2WeN,
  input  logic              p2OeN,
  input  logic              p2CsN,
  input  logic [ADDR_W-1:0] p2Addr,
  input  logic [DATA_W-1:0] p2Din,
  output logic [DATA_W-1:0] p2Dout
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd1;
  logic [DATA_W-1:0] rd2;

  // Synchronous write and read on both ports; port 2 wins a same-address write clash
  always_ff @(posedge clk) begin
    if (!p1CsN) begin
      if (!p1WeN) mem[p1Addr] <= p1Din;
      else        rd1 <= mem[p1Addr];
    end
    if (!p2CsN) begin
      if (!p2WeN) mem[p2Addr] <= p2Din;
      else        rd2 <= mem[p2Addr];
    end
  end

  assign p1Dout = p1OeN ? '0 : rd1;
  assign p2Dout = p2OeN ? '0 : rd2;

endmodule

// File: rtl/dotp_ctrl.sv
module dotp_ctrl
  import dotp_pkg::*;
#(
  parameter int VEC_LEN = 16,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aValid,
  output logic              aReady,
  input  logic              bValid,
  output logic              bReady,
  output logic              resValid,
  input  logic              resReady,
  output dpStrobe_t         strobe,
  output logic [ADDR_W-1:0] addr1,
  output logic [ADDR_W-1:0] addr2
);
  localparam int CNT_W = $clog2(VEC_LEN + 1);
  localparam int IDX_W = (VEC_LEN > 1) ? $clog2(VEC_LEN) : 1;
  localparam logic [CNT_W-1:0]  LEN_C  = CNT_W'(VEC_LEN);
  localparam logic [CNT_W-1:0]  LAST_C = CNT_W'(VEC_LEN - 1);
  localparam logic [IDX_W-1:0]  IDX_END = IDX_W'(VEC_LEN - 1);
  localparam logic [ADDR_W-1:0] B_BASE = ADDR_W'(VEC_LEN);

  dotState_t        state, stateNxt;
  logic [CNT_W-1:0] aCnt, bCnt;
  logic [IDX_W-1:0] rdIdx;
  logic             pairValid;
  logic             aFire, bFire, aLast, bLast;

  assign aReady   = (state == ST_LOAD) && (aCnt != LEN_C);
  assign bReady   = (state == ST_LOAD) && (bCnt != LEN_C);
  assign resValid = (state == ST_DONE);
  assign aFire    = aValid && aReady;
  assign bFire    = bValid && bReady;
  assign aLast    = (aCnt == LEN_C) || ((aCnt == LAST_C) && aFire);
  assign bLast    = (bCnt == LEN_C) || ((bCnt == LAST_C) && bFire);

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:    stateNxt = ST_LOAD;
      ST_LOAD:    if (aLast && bLast) stateNxt = ST_COMPUTE;
      ST_COMPUTE: if (rdIdx == IDX_END) stateNxt = ST_DRAIN;
      ST_DRAIN:   stateNxt = ST_DONE;
      ST_DONE:    if (resReady) stateNxt = ST_IDLE;
      default:    stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      aCnt      <= '0;
      bCnt      <= '0;
      rdIdx     <= '0;
      pairValid <= 1'b0;
    end else begin
      state     <= stateNxt;
      pairValid <= (state == ST_COMPUTE);
      if (state == ST_IDLE) begin
        aCnt  <= '0;
        bCnt  <= '0;
        rdIdx <= '0;
      end else begin
        if (aFire) aCnt <= aCnt + CNT_W'(1);
        if (bFire) bCnt <= bCnt + CNT_W'(1);
        if (state == ST_COMPUTE) rdIdx <= rdIdx + IDX_W'(1);
      end
    end
  end

  // Port 1 covers the a half, port 2 the b half; compute reads both halves at once
  always_comb begin
    strobe.clrAcc = (state == ST_IDLE);
    strobe.macEn  = pairValid;
    strobe.we1N   = !aFire;
    strobe.we2N   = !bFire;
    if (state == ST_COMPUTE) begin
      addr1 = ADDR_W'(rdIdx);
      addr2 = B_BASE + ADDR_W'(rdIdx);
    end else begin
      addr1 = ADDR_W'(aCnt);
      addr2 = B_BASE + ADDR_W'(bCnt);
    end
  end

  AST_LOAD_COMPLETE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD) |=> ((state != ST_COMPUTE) || ((aCnt == LEN_C) && (bCnt == LEN_C)))); // R2
  AST_DRAIN_MAC: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN) |-> strobe.macEn); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resReady) |=> resValid); // R6
  AST_INPUTS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_COMPUTE) || (state == ST_DRAIN) || (state == ST_DONE)) |-> (!aReady && !bReady)); // R7

endmodule

// File: rtl/dotp_datapath.sv
module dotp_datapath
  import dotp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter int ACC_W  = 36
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] addr1,
  input  logic [ADDR_W-1:0] addr2,
  input  logic [DATA_W-1:0] aData,
  input  logic [DATA_W-1:0] bData,
  output logic [ACC_W-1:0]  acc
);
  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W-1:0] q1, q2;
  logic [PROD_W-1:0] prod;

  dotp_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk    (clk),
    .p1WeN  (strobe.we1N),
    .p1OeN  (1'b0),
    .p1CsN  (1'b0),
    .p1Addr (addr1),
    .p1Din  (aData),
    .p1Dout (q1),
    .p2WeN  (strobe.we2N),
    .p2OeN  (1'b0),
    .p2CsN  (1'b0),
    .p2Addr (addr2),
    .p2Din  (bData),
    .p2Dout (q2)
  );

  assign prod = q1 * q2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              acc <= '0;
    else if (strobe.clrAcc) acc <= '0;
    else if (strobe.macEn)  acc <= acc + ACC_W'(prod);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.macEn && !strobe.clrAcc) |=> (acc >= $past(acc))); // R4
  AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.macEn && !strobe.clrAcc) |=> $stable(acc)); // R6
  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrAcc |=> (acc == '0)); // R6

endmodule

// File: rtl/dotp_top.sv
module dotp_top
  import dotp_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int VEC_LEN = 16,
  parameter int ACC_W   = 2 * DATA_W + $clog2(VEC_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] aData,
  input  logic              aValid,
  output logic              aReady,
  input  logic [DATA_W-1:0] bData,
  input  logic              bValid,
  output logic              bReady,
  output logic [ACC_W-1:0]  resData,
  output logic              resValid,
  input  logic              resReady
);
  localparam int ADDR_W = $clog2(2 * VEC_LEN);

  dpStrobe_t         strobe;
  logic [ADDR_W-1:0] addr1, addr2;

  dotp_ctrl #(.VEC_LEN(VEC_LEN), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .aValid   (aValid),
    .aReady   (aReady),
    .bValid   (bValid),
    .bReady   (bReady),
    .resValid (resValid),
    .resReady (resReady),
    .strobe   (strobe),
    .addr1    (addr1),
    .addr2    (addr2)
  );

  dotp_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ACC_W(ACC_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .addr1  (addr1),
    .addr2  (addr2),
    .aData  (aData),
    .bData  (bData),
    .acc    (resData)
  );

endmodule

// File: tb/sim_dotp_top.sv
module sim_dotp_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int VL = 16;
  localparam int AW = 36;
  localparam int NCASE = 5;
  // Per case: a base/step, b base/step, feed mode
  // mode 0 lockstep, 1 all a then b, 2 pseudo-random stalls, 3 all b then a
  localparam int unsigned C_ABASE [NCASE] = '{1, 100, 65535, 40000, 5};
  localparam int unsigned C_ASTEP [NCASE] = '{1, 7, 0, 1234, 3};
  localparam int unsigned C_BBASE [NCASE] = '{1, 3000, 65535, 123, 9};
  localparam int unsigned C_BSTEP [NCASE] = '{1, 13, 0, 4321, 11};
  localparam int          C_MODE  [NCASE] = '{0, 1, 0, 2, 3};

  logic clk = 1'b0;
  logic rstN;
  logic [DW-1:0] aData, bData;
  logic aValid, bValid, aReady, bReady, resValid, resReady;
  logic [AW-1:0] resData;
  logic [15:0] lfsr = 16'hACE1;
  logic [DW-1:0] aVec [VL];
  logic [DW-1:0] bVec [VL];
  int nChecks = 0;
  int nFail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dotp_top u0 (
    .clk(clk), .rstN(rstN),
    .aData(aData), .aValid(aValid), .aReady(aReady),
    .bData(bData), .bValid(bValid), .bReady(bReady),
    .resData(resData), .resValid(resValid), .resReady(resReady)
  );

  task automatic chk(input bit ok, input string req, input longint unsigned act,
                     input longint unsigned exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] elem(input int unsigned base, input int unsigned step,
                                         input int i);
    int unsigned v;
    v = base + step * i;
    return v[DW-1:0];
  endfunction

  // Loads the vectors in aVec/bVec with the given mode, then checks result handling
  task automatic run_vectors(input int mode, input longint unsigned expv);
    int ai = 0;
    int bi = 0;
    int guard = 0;
    int lowCnt = 0;
    logic aF, bF;
    logic [AW-1:0] held;
    while (!(aReady || bReady) && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    guard = 0;
    while ((ai < VL || bi < VL) && guard < 2000) begin
      guard++;
      chk(aReady == (ai < VL), "R2 aReady during load", 64'(aReady), 64'(ai < VL));
      chk(bReady == (bi < VL), "R2 bReady during load", 64'(bReady), 64'(bi < VL));
      case (mode)
        1: begin aValid = 1'b1; bValid = (ai >= VL); end
        2: begin aValid = lfsr[0]; bValid = lfsr[5]; end
        3: begin bValid = 1'b1; aValid = (bi >= VL); end
        default: begin aValid = 1'b1; bValid = 1'b1; end
      endcase
      aData = (ai < VL) ? aVec[ai] : 16'hDEAD;   // extra beats must be ignored (R2)
      bData = (bi < VL) ? bVec[bi] : 16'hBEEF;
      aF = aValid && aReady;
      bF = bValid && bReady;
      @(posedge clk);
      ai += int'(aF);
      bi += int'(bF);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      @(negedge clk);
    end
    // Junk offered while the block computes (R7)
    aValid = 1'b1; bValid = 1'b1; aData = 16'h1234; bData = 16'h4321;
    while (!resValid && lowCnt < 100) begin
      chk(!aReady && !bReady, "R7 inputs closed after load", 64'({aReady, bReady}), 0);
      lowCnt++;
      @(negedge clk);
    end
    chk(lowCnt == 17, "R5 latency edges", 64'(lowCnt), 17);
    chk(resData == AW'(expv), "R3 R4 dot product value", 64'(resData), expv);
    held = resData;
    repeat (3) begin
      @(negedge clk);
      chk(resValid && resData == held, "R6 hold under stall", 64'(resData), 64'(held));
    end
    aValid = 1'b0; bValid = 1'b0; resReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    resReady = 1'b0;
    chk(!resValid, "R6 result released", 64'(resValid), 0);
  endtask

  task automatic run_case(input int idx);
    longint unsigned expv = 0;
    for (int i = 0; i < VL; i++) begin
      aVec[i] = elem(C_ABASE[idx], C_ASTEP[idx], i);
      bVec[i] = elem(C_BBASE[idx], C_BSTEP[idx], i);
      expv += longint'(aVec[i]) * longint'(bVec[i]);
    end
    run_vectors(C_MODE[idx], expv);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; aValid = 1'b0; bValid = 1'b0; resReady = 1'b0;
    aData = '0; bData = '0;
    repeat (3) @(negedge clk);
    chk(!aReady && !bReady, "R1 ready low in reset", 64'({aReady, bReady}), 0);
    chk(!resValid, "R1 resValid low in reset", 64'(resValid), 0);
    chk(resData == '0, "R1 resData zero in reset", 64'(resData), 0);
    rstN = 1'b1;

    // Table of vector cases
    for (int c = 0; c < NCASE; c++) run_case(c);

    // Directed: reset in mid-load drops the partial vectors (R1)
    while (!aReady) @(negedge clk);
    aValid = 1'b1; aData = 16'd9999;
    repeat (5) @(negedge clk);
    aValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    chk(!aReady && !bReady && !resValid, "R1 outputs low after mid-load reset",
        64'({aReady, bReady, resValid}), 0);
    chk(resData == '0, "R1 accumulator cleared by reset", 64'(resData), 0);
    rstN = 1'b1;
    run_case(0);

    // Directed: back-to-back runs start from a clear accumulator (R6)
    run_case(4);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule